// File: doc/BRIEF.md
# Load/MAC Register Scoreboard Interlock

This block sits at the issue stage of an in-order core whose load pipeline and multiply-accumulate (MAC) pipeline finish at times the issue stage cannot predict. A load may miss the data cache, and a MAC can write its result back after any one of several multiplier stages. For each register, the block records whether a result is still owed and which long-latency unit owes it. Every cycle it compares the register numbers of the instruction being decoded against that record and decides whether issue must hold.

A result that reaches the register file in the same cycle as the lookup does not cause a stall. The block reports it on a per-operand forward-hit flag so that the bypass network can select it. Instructions that use no pending register continue to issue. Younger independent work can therefore finish ahead of an older load or MAC. A pipeline flush clears the whole record, and so does the synchronous reset.

Top module: `lmac_scoreboard`

## Requirements
- R1: After synchronous reset (`rst` high), no register is pending. An issue that reads any registers does not stall.
- R2: An accepted issue with `iss_kind_i` = 2'b01 (load) and `iss_dst_vld_i` high marks its destination register pending, owned by the load unit. From the next cycle, an issue that reads that register through a valid source stalls until a load writeback to it.
- R3: An accepted issue with `iss_kind_i` = 2'b10 (MAC) marks its destination register pending, owned by the MAC unit. The register stays pending for any number of cycles until a MAC writeback pulse for it arrives.
- R4: A writeback from the unit that does not own a pending register leaves that register pending.
- R5: An issue whose valid sources and destination are all non-pending does not stall, even while other registers are pending.
- R6: If a valid source is pending and the owning unit's writeback for that register arrives in the same cycle, `stall_o` stays low and the bit of `fwd_hit_o` for that source slot is high. Source slot s occupies bits [4s+3:4s] of `iss_src_idx_i`.
- R7: A source slot whose bit in `iss_src_vld_i` is low never causes a stall and never raises its forward-hit bit.
- R8: An issue whose valid destination is pending, and is not being written back in that cycle, stalls.
- R9: If a register's writeback and an accepted new load or MAC issue to that same register fall in one cycle, the register stays pending and the new issuer owns it.
- R10: A `flush_i` pulse clears every pending register by the next cycle.
- R11: A stalled issue records nothing, and an accepted issue with `iss_kind_i` = 2'b00 (ALU) records nothing.
- R12: `stall_o` and `fwd_hit_o` are low whenever `iss_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Pipeline flush; clears all pending registers |
| iss_valid_i | input | 1 | An instruction is presented for issue |
| iss_kind_i | input | 2 | 00 ALU, 01 load, 10 MAC (11 treated as ALU) |
| iss_dst_idx_i | input | 4 | Destination register number |
| iss_dst_vld_i | input | 1 | Destination register is written |
| iss_src_idx_i | input | 12 | Three packed source register numbers; slot s in bits [4s+3:4s] |
| iss_src_vld_i | input | 3 | Per-slot source valid |
| ld_wb_vld_i | input | 1 | Load unit writes back this cycle |
| ld_wb_idx_i | input | 4 | Register written by the load unit |
| mac_wb_vld_i | input | 1 | MAC unit writes back this cycle |
| mac_wb_idx_i | input | 4 | Register written by the MAC unit |
| stall_o | output | 1 | Hold the presented instruction |
| fwd_hit_o | output | 3 | Per-slot source satisfied by a same-cycle writeback |

## Verification
The checker tests these properties on every cycle: stall and forward-hit stay quiet without a valid issue, forward-hit never appears on an invalid slot, accepted load or MAC issues leave their destination pending on the next cycle, ALU issues never add pending bits, and flush empties the table. Some behaviours involve several cycles of history, and only the bench's scenarios show them. These are: the ownership rule, where a writeback from the other unit must not release a register; the wait for a MAC writeback of arbitrary latency; set-over-clear arbitration; write-after-write holds; and a stalled load that must not claim its destination.

// File: rtl/lmac_sb_pkg.sv
package lmac_sb_pkg;
  // Issue kind / register owner encoding, shared by table, lookup and top.
  localparam logic [1:0] KIND_ALU  = 2'b00;
  localparam logic [1:0] KIND_LOAD = 2'b01;
  localparam logic [1:0] KIND_MAC  = 2'b10;

  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_LOAD = 2'b01,
    OWN_MAC  = 2'b10
  } owner_e;
endpackage

// File: rtl/lmac_sb_table.sv
module lmac_sb_table
  import lmac_sb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush_i,
  input  logic                set_en_i,
  input  logic [REG_W-1:0]    set_idx_i,
  input  owner_e              set_own_i,
  input  logic                ld_wb_vld_i,
  input  logic [REG_W-1:0]    ld_wb_idx_i,
  input  logic                mac_wb_vld_i,
  input  logic [REG_W-1:0]    mac_wb_idx_i,
  output logic [NUM_REGS-1:0] pend_o,
  output logic [NUM_REGS-1:0] wb_hit_o
);

  // One pending bit and one owner tag per architectural register.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [REG_W-1:0] RIDX = REG_W'(r);
    logic   pend_q;
    owner_e own_q;
    logic   ld_match;
    logic   mac_match;
    logic   set_here;

    assign ld_match  = ld_wb_vld_i  && (ld_wb_idx_i  == RIDX) && (own_q == OWN_LOAD);
    assign mac_match = mac_wb_vld_i && (mac_wb_idx_i == RIDX) && (own_q == OWN_MAC);
    assign set_here  = set_en_i && (set_idx_i == RIDX);

    // Writeback releases the register only when issued by its owner.
    assign wb_hit_o[r] = pend_q && (ld_match || mac_match);
    assign pend_o[r]   = pend_q;

    // Priority: reset/flush, then new set, then owner's clear.
    always_ff @(posedge clk) begin
      if (rst || flush_i) begin
        pend_q <= 1'b0;
        own_q  <= OWN_NONE;
      end else if (set_here) begin
        pend_q <= 1'b1;
        own_q  <= set_own_i;
      end else if (wb_hit_o[r]) begin
        pend_q <= 1'b0;
        own_q  <= OWN_NONE;
      end
    end
  end

endmodule

// File: rtl/lmac_sb_lookup.sv
module lmac_sb_lookup #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic [REG_W-1:0]    idx_i,
  input  logic                vld_i,
  input  logic [NUM_REGS-1:0] pend_i,
  input  logic [NUM_REGS-1:0] wb_hit_i,
  output logic                blocked_o,
  output logic                fwd_o
);
  logic busy;
  logic arriving;

  assign busy      = pend_i[idx_i];
  assign arriving  = wb_hit_i[idx_i];
  assign blocked_o = vld_i && busy && !arriving;
  assign fwd_o     = vld_i && busy && arriving;
endmodule

// File: rtl/lmac_scoreboard.sv
module lmac_scoreboard
  import lmac_sb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_SRC  = 3,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush_i,
  input  logic                     iss_valid_i,
  input  logic [1:0]               iss_kind_i,
  input  logic [REG_W-1:0]         iss_dst_idx_i,
  input  logic                     iss_dst_vld_i,
  input  logic [NUM_SRC*REG_W-1:0] iss_src_idx_i,
  input  logic [NUM_SRC-1:0]       iss_src_vld_i,
  input  logic                     ld_wb_vld_i,
  input  logic [REG_W-1:0]         ld_wb_idx_i,
  input  logic                     mac_wb_vld_i,
  input  logic [REG_W-1:0]         mac_wb_idx_i,
  output logic                     stall_o,
  output logic [NUM_SRC-1:0]       fwd_hit_o
);

  logic [NUM_REGS-1:0] pend_q;
  logic [NUM_REGS-1:0] wb_hit;
  logic [NUM_SRC-1:0]  src_blk;
  logic [NUM_SRC-1:0]  src_fwd;
  logic                dst_blk;
  logic                long_kind;
  logic                set_en;
  owner_e              set_own;

  lmac_sb_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_table (
    .clk         (clk),
    .rst         (rst),
    .flush_i     (flush_i),
    .set_en_i    (set_en),
    .set_idx_i   (iss_dst_idx_i),
    .set_own_i   (set_own),
    .ld_wb_vld_i (ld_wb_vld_i),
    .ld_wb_idx_i (ld_wb_idx_i),
    .mac_wb_vld_i(mac_wb_vld_i),
    .mac_wb_idx_i(mac_wb_idx_i),
    .pend_o      (pend_q),
    .wb_hit_o    (wb_hit)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    lmac_sb_lookup #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_lookup (
      .idx_i    (iss_src_idx_i[s*REG_W +: REG_W]),
      .vld_i    (iss_src_vld_i[s]),
      .pend_i   (pend_q),
      .wb_hit_i (wb_hit),
      .blocked_o(src_blk[s]),
      .fwd_o    (src_fwd[s])
    );
  end

  // Write-after-write hold: destination still owed by an older producer.
  assign dst_blk = iss_dst_vld_i && pend_q[iss_dst_idx_i] && !wb_hit[iss_dst_idx_i];

  assign stall_o   = iss_valid_i && ((|src_blk) || dst_blk);
  assign fwd_hit_o = iss_valid_i ? src_fwd : '0;

  assign long_kind = (iss_kind_i == KIND_LOAD) || (iss_kind_i == KIND_MAC);
  assign set_en    = iss_valid_i && !stall_o && iss_dst_vld_i && long_kind;
  assign set_own   = (iss_kind_i == KIND_MAC) ? OWN_MAC : OWN_LOAD;

endmodule

// File: rtl/lmac_scoreboard_chk.sv
module lmac_scoreboard_chk
  import lmac_sb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_SRC  = 3,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst,
  input logic                flush_i,
  input logic                iss_valid_i,
  input logic [1:0]          iss_kind_i,
  input logic [REG_W-1:0]    iss_dst_idx_i,
  input logic                iss_dst_vld_i,
  input logic [NUM_SRC-1:0]  iss_src_vld_i,
  input logic                stall_o,
  input logic [NUM_SRC-1:0]  fwd_hit_o,
  input logic [NUM_REGS-1:0] pend_q
);
  logic accept;
  assign accept = iss_valid_i && !stall_o && iss_dst_vld_i && !flush_i;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !iss_valid_i |-> (!stall_o && fwd_hit_o == '0)); // R12

  AST_FWD_ONLY_VALID_SRC: assert property (@(posedge clk) disable iff (rst)
    $countones(fwd_hit_o & ~iss_src_vld_i) == 0); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (pend_q == '0)); // R10

  AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (rst)
    (accept && iss_kind_i == KIND_LOAD) |=> pend_q[$past(iss_dst_idx_i)]); // R2

  AST_MAC_MARKS: assert property (@(posedge clk) disable iff (rst)
    (accept && iss_kind_i == KIND_MAC) |=> pend_q[$past(iss_dst_idx_i)]); // R3

  AST_ALU_NO_MARK: assert property (@(posedge clk) disable iff (rst)
    (iss_kind_i == KIND_ALU) |=> ((pend_q & ~$past(pend_q)) == '0)); // R11

endmodule

bind lmac_scoreboard lmac_scoreboard_chk #(
  .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .REG_W(REG_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flush_i      (flush_i),
  .iss_valid_i  (iss_valid_i),
  .iss_kind_i   (iss_kind_i),
  .iss_dst_idx_i(iss_dst_idx_i),
  .iss_dst_vld_i(iss_dst_vld_i),
  .iss_src_vld_i(iss_src_vld_i),
  .stall_o      (stall_o),
  .fwd_hit_o    (fwd_hit_o),
  .pend_q       (pend_q)
);

// File: tb/lmac_scoreboard_tb.sv
module lmac_scoreboard_tb;
  localparam logic [1:0] K_ALU = 2'b00, K_LD = 2'b01, K_MAC = 2'b10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_i = 1'b0;
  logic        iss_valid_i = 1'b0;
  logic [1:0]  iss_kind_i = 2'b00;
  logic [3:0]  iss_dst_idx_i = '0;
  logic        iss_dst_vld_i = 1'b0;
  logic [11:0] iss_src_idx_i = '0;
  logic [2:0]  iss_src_vld_i = '0;
  logic        ld_wb_vld_i = 1'b0;
  logic [3:0]  ld_wb_idx_i = '0;
  logic        mac_wb_vld_i = 1'b0;
  logic [3:0]  mac_wb_idx_i = '0;
  logic        stall_o;
  logic [2:0]  fwd_hit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lmac_scoreboard u_dut (
    .clk(clk), .rst(rst), .flush_i(flush_i),
    .iss_valid_i(iss_valid_i), .iss_kind_i(iss_kind_i),
    .iss_dst_idx_i(iss_dst_idx_i), .iss_dst_vld_i(iss_dst_vld_i),
    .iss_src_idx_i(iss_src_idx_i), .iss_src_vld_i(iss_src_vld_i),
    .ld_wb_vld_i(ld_wb_vld_i), .ld_wb_idx_i(ld_wb_idx_i),
    .mac_wb_vld_i(mac_wb_vld_i), .mac_wb_idx_i(mac_wb_idx_i),
    .stall_o(stall_o), .fwd_hit_o(fwd_hit_o)
  );

  // Drive one cycle of stimulus at the falling edge; outputs settle 1 ns later.
  task automatic go(input logic v, input logic [1:0] k, input logic [3:0] d,
                    input logic dv, input logic [3:0] s0, input logic [3:0] s1,
                    input logic [3:0] s2, input logic [2:0] sv,
                    input logic lv, input logic [3:0] li,
                    input logic mv, input logic [3:0] mi, input logic fl);
    @(negedge clk);
    iss_valid_i = v; iss_kind_i = k; iss_dst_idx_i = d; iss_dst_vld_i = dv;
    iss_src_idx_i = {s2, s1, s0}; iss_src_vld_i = sv;
    ld_wb_vld_i = lv; ld_wb_idx_i = li; mac_wb_vld_i = mv; mac_wb_idx_i = mi;
    flush_i = fl;
    #1;
  endtask

  task automatic idle();
    go(0, K_ALU, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
  endtask

  // Read one register through source slot 0 with an ALU issue.
  task automatic rd(input logic [3:0] r);
    go(1, K_ALU, 0, 0, r, 0, 0, 3'b001, 0, 0, 0, 0, 0);
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    go(1, K_ALU, 1, 1, 1, 2, 3, 3'b111, 0, 0, 0, 0, 0);
    chk("R1 stall after reset", {2'b0, stall_o}, 3'b000);
    chk("R1 fwd after reset", fwd_hit_o, 3'b000);
  endtask

  task automatic t_load();
    go(1, K_LD, 5, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    chk("R2 load issue accepted", {2'b0, stall_o}, 3'b000);
    rd(5);
    chk("R2 read pending load dst", {2'b0, stall_o}, 3'b001);
    go(1, K_ALU, 7, 1, 6, 0, 0, 3'b001, 0, 0, 0, 0, 0);
    chk("R5 independent issue", {2'b0, stall_o}, 3'b000);
    go(1, K_ALU, 0, 0, 5, 0, 0, 3'b001, 0, 0, 1, 5, 0);
    chk("R4 MAC wb on load-owned reg", {2'b0, stall_o}, 3'b001);
    go(1, K_ALU, 0, 0, 0, 0, 5, 3'b100, 1, 5, 0, 0, 0);
    chk("R6 same-cycle load wb stall", {2'b0, stall_o}, 3'b000);
    chk("R6 forward hit slot 2", fwd_hit_o, 3'b100);
    rd(5);
    chk("R2 released after load wb", {2'b0, stall_o}, 3'b000);
    chk("R2 no fwd after release", fwd_hit_o, 3'b000);
  endtask

  task automatic t_mac();
    go(1, K_MAC, 7, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      rd(7);
      chk("R3 MAC result still owed", {2'b0, stall_o}, 3'b001);
    end
    go(0, K_ALU, 0, 0, 0, 0, 0, 3'b000, 1, 7, 0, 0, 0);
    rd(7);
    chk("R4 load wb on MAC-owned reg", {2'b0, stall_o}, 3'b001);
    go(0, K_ALU, 0, 0, 0, 0, 0, 3'b000, 0, 0, 1, 7, 0);
    rd(7);
    chk("R3 released after MAC wb", {2'b0, stall_o}, 3'b000);
  endtask

  task automatic t_srcvld();
    go(1, K_LD, 2, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    go(1, K_ALU, 0, 0, 0, 2, 0, 3'b101, 0, 0, 0, 0, 0);
    chk("R7 invalid slot ignored", {2'b0, stall_o}, 3'b000);
    go(1, K_ALU, 0, 0, 0, 2, 0, 3'b101, 1, 2, 0, 0, 0);
    chk("R7 no fwd on invalid slot", fwd_hit_o, 3'b000);
    go(1, K_LD, 2, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    go(0, K_ALU, 0, 0, 2, 2, 2, 3'b111, 0, 0, 0, 0, 0);
    chk("R12 no stall without valid", {2'b0, stall_o}, 3'b000);
    go(0, K_ALU, 0, 0, 2, 2, 2, 3'b111, 1, 2, 0, 0, 0);
    chk("R12 no fwd without valid", fwd_hit_o, 3'b000);
    rd(2);
    chk("R2 cleared by idle-cycle wb", {2'b0, stall_o}, 3'b000);
  endtask

  task automatic t_waw();
    go(1, K_MAC, 3, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    go(1, K_ALU, 3, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    chk("R8 WAW on pending dst", {2'b0, stall_o}, 3'b001);
    go(1, K_LD, 9, 1, 3, 0, 0, 3'b001, 0, 0, 0, 0, 0);
    chk("R11 load held by source", {2'b0, stall_o}, 3'b001);
    rd(9);
    chk("R11 stalled load did not record", {2'b0, stall_o}, 3'b000);
    go(1, K_ALU, 3, 1, 0, 0, 0, 3'b000, 0, 0, 1, 3, 0);
    chk("R8 dst released same cycle", {2'b0, stall_o}, 3'b000);
    go(1, K_ALU, 10, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    rd(10);
    chk("R11 ALU dst not recorded", {2'b0, stall_o}, 3'b000);
  endtask

  task automatic t_set_wins();
    go(1, K_LD, 4, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    go(1, K_MAC, 4, 1, 0, 0, 0, 3'b000, 1, 4, 0, 0, 0);
    chk("R9 MAC reissue accepted", {2'b0, stall_o}, 3'b000);
    rd(4);
    chk("R9 set beats clear", {2'b0, stall_o}, 3'b001);
    go(1, K_ALU, 0, 0, 4, 0, 0, 3'b001, 1, 4, 0, 0, 0);
    chk("R9 new owner is MAC", {2'b0, stall_o}, 3'b001);
    go(0, K_ALU, 0, 0, 0, 0, 0, 3'b000, 0, 0, 1, 4, 0);
    rd(4);
    chk("R3 MAC wb frees reissued reg", {2'b0, stall_o}, 3'b000);
  endtask

  task automatic t_flush();
    go(1, K_LD, 1, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    go(1, K_MAC, 8, 1, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    go(1, K_ALU, 0, 0, 1, 8, 0, 3'b011, 0, 0, 0, 0, 0);
    chk("R10 pending before flush", {2'b0, stall_o}, 3'b001);
    go(0, K_ALU, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 1);
    go(1, K_ALU, 1, 1, 1, 8, 0, 3'b011, 0, 0, 0, 0, 0);
    chk("R10 flush cleared table", {2'b0, stall_o}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_mac();
    t_srcvld();
    t_waw();
    t_set_wins();
    t_flush();
    idle();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule